// File: doc/BRIEF.md
# ECC First-Error Capture and Interrupt

This block sits next to the ECC checker of a memory controller. When the checker flags an error, the block keeps a record of the first one: its syndrome, whether one bit or several were wrong, the ID of the requester, and the word address. It then raises an interrupt so that software can read the record and scrub the faulty location. Any error that arrives while a record is held is dropped. A new error can be recorded only after software writes a one to status bit 0. The checker itself does the detection and correction; this block only records errors and signals them.

A one-bit control port has two targets. Select 0 writes the reporting enable. Select 1 is the write-one-to-clear port for status bit 0. The record sits in a 32-bit log word, a low address word and a high address word.

The control logic is a two-state machine:
- `ST_ARMED`: no record is held.
- `ST_HELD`: a record is held and status bit 0 reads 1.

It has four transitions:
- **capture** (`ST_ARMED`→`ST_HELD`): an error strobe arrives while reporting is enabled.
- **release** (`ST_HELD`→`ST_ARMED`): a clear arrives with no enabled error in the same cycle.
- **recapture** (`ST_HELD`→`ST_HELD`): a clear and an enabled error arrive in the same cycle.
- **drop** (`ST_HELD`→`ST_HELD`): an error arrives with no clear. The record is kept.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset, the log, both address words, the status byte, the enable and `irq` are all zero.
- R2: Writing `cfg_wr_bit` with `cfg_wr_sel`=0 sets the enable. While the enable is 0, an error strobe changes no register and raises no interrupt.
- R3: A captured error puts its syndrome in log bits [7:0] and its requester ID in log bits [23:16]. Log bits [15:9] and [31:24] always read 0.
- R4: Log bit [8] holds 0 for a single-bit error (`err_multi`=0) and 1 for a multi-bit error (`err_multi`=1).
- R5: The low address word holds the word address in bits [31:2], with bits [1:0] at 0. The high address word holds word-address bits above the lower 30, zero-extended.
- R6: Registers are captured at the clock edge that samples the strobe. Status bit 0 reads 1 from that edge on. Status bits [7:1] always read 0.
- R7: `irq` is registered. It rises one cycle after status bit 0 becomes 1 and falls one cycle after status bit 0 is cleared.
- R8: A write with `cfg_wr_sel`=1 and `cfg_wr_bit`=1 clears status bit 0 and zeroes the log and address words. The same write with `cfg_wr_bit`=0 has no effect.
- R9: An error that arrives while status bit 0 is 1, with no clear in the same cycle, leaves the log, the address words and the status unchanged.
- R10: When a clear and an enabled error arrive in the same cycle, the clear acts first. The new error is then captured and status bit 0 stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_valid | input | 1 | Error-detect strobe from the ECC checker |
| err_multi | input | 1 | Error type: 1 = multi-bit, 0 = single-bit |
| err_syndrome | input | 8 | Syndrome that flagged the error |
| err_requester | input | 8 | ID of the requester whose access failed |
| err_waddr | input | ADDR_W-2 | Word address of the failing access |
| cfg_wr_en | input | 1 | Control write strobe |
| cfg_wr_sel | input | 1 | Write target: 0 = enable, 1 = status clear |
| cfg_wr_bit | input | 1 | Write data bit |
| ctl_enable | output | 1 | Current reporting enable |
| log_q | output | 32 | Held log word |
| addr_lo_q | output | 32 | Held low address word |
| addr_hi_q | output | 32 | Held high address word |
| int_status | output | 8 | Interrupt status (bit 0 only) |
| irq | output | 1 | Interrupt request |

## Verification
Two events can fall in the same cycle: a software clear of status bit 0 and a new error strobe. The bench provokes this by driving a status write of 1 and an error strobe, with fresh syndrome, requester and address, on the same clock edge while a record is held. The test passes only if the log and address words then show the new error's fields and the status stays set. The test also checks the opposite ordering case: an error with no clear must leave the held record untouched.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;

    typedef enum logic [0:0] {
        ST_ARMED = 1'b0,
        ST_HELD  = 1'b1
    } cap_state_e;

    localparam int SYN_W  = 8;
    localparam int RID_W  = 8;
    localparam int WORD_W = 32;
    localparam int STAT_W = 8;

    localparam logic SEL_ENABLE = 1'b0;
    localparam logic SEL_STATUS = 1'b1;

endpackage

// File: rtl/ecc_cap_fsm.sv
module ecc_cap_fsm
    import ecc_cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic err_valid,
    input  logic clr_req,
    output logic capture,
    output logic wipe,
    output logic held
);

    cap_state_e state_q;
    cap_state_e state_d;
    logic       take_err;

    assign take_err = enable && err_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: capture, release, recapture, drop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: begin
                if (take_err) state_d = ST_HELD;
            end
            ST_HELD: begin
                if (clr_req && !take_err) state_d = ST_ARMED;
            end
            default: state_d = ST_ARMED;
        endcase
    end

    // outputs
    always_comb begin
        capture = 1'b0;
        wipe    = 1'b0;
        held    = 1'b0;
        unique case (state_q)
            ST_ARMED: begin
                capture = take_err;
            end
            ST_HELD: begin
                held    = 1'b1;
                capture = take_err && clr_req;
                wipe    = clr_req && !take_err;
            end
            default: ;
        endcase
    end

    // R10
    recapture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && clr_req && take_err) |=> (state_q == ST_HELD));

    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && clr_req && !take_err) |=> (state_q == ST_ARMED));

endmodule

// File: rtl/ecc_cap_regs.sv
module ecc_cap_regs
    import ecc_cap_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture,
    input  logic                  wipe,
    input  logic                  err_multi,
    input  logic [SYN_W-1:0]      err_syndrome,
    input  logic [RID_W-1:0]      err_requester,
    input  logic [ADDR_W-3:0]     err_waddr,
    output logic [WORD_W-1:0]     log_q,
    output logic [WORD_W-1:0]     addr_lo_q,
    output logic [WORD_W-1:0]     addr_hi_q
);

    localparam int LO_BITS = WORD_W - 2;
    localparam int HI_W    = ADDR_W - WORD_W;

    logic [WORD_W-1:0] log_d;
    logic [WORD_W-1:0] lo_d;
    logic [WORD_W-1:0] hi_d;

    always_comb begin
        log_d        = '0;
        log_d[7:0]   = err_syndrome;
        log_d[8]     = err_multi;
        log_d[23:16] = err_requester;
        lo_d         = {err_waddr[LO_BITS-1:0], 2'b00};
    end

    generate
        if (HI_W > 0) begin : g_upper
            assign hi_d = {{(WORD_W-HI_W){1'b0}}, err_waddr[ADDR_W-3:LO_BITS]};
        end else begin : g_no_upper
            assign hi_d = '0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            log_q     <= '0;
            addr_lo_q <= '0;
            addr_hi_q <= '0;
        end else if (capture) begin
            log_q     <= log_d;
            addr_lo_q <= lo_d;
            addr_hi_q <= hi_d;
        end else if (wipe) begin
            log_q     <= '0;
            addr_lo_q <= '0;
            addr_hi_q <= '0;
        end
    end

    // R3
    log_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (log_q[15:9] == 7'd0) && (log_q[31:24] == 8'd0));

    // R5
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_lo_q[1:0] == 2'b00);

endmodule

// File: rtl/ecc_cap_ctrl.sv
module ecc_cap_ctrl
    import ecc_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic              wr_bit,
    input  logic              held,
    output logic              enable,
    output logic              clr_req,
    output logic [STAT_W-1:0] status,
    output logic              irq
);

    logic enable_q;
    logic irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
        end else if (wr_en && (wr_sel == SEL_ENABLE)) begin
            enable_q <= wr_bit;
        end
    end

    assign clr_req = wr_en && (wr_sel == SEL_STATUS) && wr_bit;

    always_comb begin
        status    = '0;
        status[0] = held;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |status;
        end
    end

    assign enable = enable_q;
    assign irq    = irq_q;

    // R7
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |=> irq);

    // R7
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(held) |=> !irq);

endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
    import ecc_cap_pkg::*;
#(
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_valid,
    input  logic              err_multi,
    input  logic [7:0]        err_syndrome,
    input  logic [7:0]        err_requester,
    input  logic [ADDR_W-3:0] err_waddr,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_sel,
    input  logic              cfg_wr_bit,
    output logic              ctl_enable,
    output logic [31:0]       log_q,
    output logic [31:0]       addr_lo_q,
    output logic [31:0]       addr_hi_q,
    output logic [7:0]        int_status,
    output logic              irq
);

    logic enable;
    logic clr_req;
    logic capture;
    logic wipe;
    logic held;

    ecc_cap_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_wr_sel),
        .wr_bit  (cfg_wr_bit),
        .held    (held),
        .enable  (enable),
        .clr_req (clr_req),
        .status  (int_status),
        .irq     (irq)
    );

    ecc_cap_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .err_valid (err_valid),
        .clr_req   (clr_req),
        .capture   (capture),
        .wipe      (wipe),
        .held      (held)
    );

    ecc_cap_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .capture       (capture),
        .wipe          (wipe),
        .err_multi     (err_multi),
        .err_syndrome  (err_syndrome),
        .err_requester (err_requester),
        .err_waddr     (err_waddr),
        .log_q         (log_q),
        .addr_lo_q     (addr_lo_q),
        .addr_hi_q     (addr_hi_q)
    );

    assign ctl_enable = enable;

    // R9
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held && err_valid && !clr_req) |=>
            ($stable(log_q) && $stable(addr_lo_q) && $stable(addr_hi_q) && int_status[0]));

    // R2
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && !enable) |=> (int_status == 8'd0));

    // R6
    capture_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && enable && err_valid) |=> int_status[0]);

    // R6
    status_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_status[7:1] == 7'd0);

endmodule

// File: tb/sim_ecc_err_capture.sv
`timescale 1ns/1ps
module sim_ecc_err_capture;

    localparam int AW = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          err_valid = 1'b0;
    logic          err_multi = 1'b0;
    logic [7:0]    err_syndrome = '0;
    logic [7:0]    err_requester = '0;
    logic [AW-3:0] err_waddr = '0;
    logic          cfg_wr_en = 1'b0;
    logic          cfg_wr_sel = 1'b0;
    logic          cfg_wr_bit = 1'b0;
    logic          ctl_enable;
    logic [31:0]   log_q;
    logic [31:0]   addr_lo_q;
    logic [31:0]   addr_hi_q;
    logic [7:0]    int_status;
    logic          irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    ecc_err_capture #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .err_valid(err_valid), .err_multi(err_multi),
        .err_syndrome(err_syndrome), .err_requester(err_requester),
        .err_waddr(err_waddr),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_bit(cfg_wr_bit),
        .ctl_enable(ctl_enable), .log_q(log_q), .addr_lo_q(addr_lo_q),
        .addr_hi_q(addr_hi_q), .int_status(int_status), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_log(input logic m, input logic [7:0] s, input logic [7:0] r);
        return {8'd0, r, 7'd0, m, s};
    endfunction

    // one cycle of stimulus, applied at a falling edge and removed at the next
    task automatic drive(input bit e, input logic m, input logic [7:0] s, input logic [7:0] r,
                         input logic [AW-3:0] a, input bit w, input logic sel, input logic b);
        @(negedge clk);
        err_valid     = e;
        err_multi     = m;
        err_syndrome  = s;
        err_requester = r;
        err_waddr     = a;
        cfg_wr_en     = w;
        cfg_wr_sel    = sel;
        cfg_wr_bit    = b;
        @(negedge clk);
        err_valid = 1'b0;
        cfg_wr_en = 1'b0;
    endtask

    task automatic check_rec(input string req, input logic m, input logic [7:0] s,
                             input logic [7:0] r, input logic [AW-3:0] a);
        chk({req, " log"}, log_q, exp_log(m, s, r));
        chk({req, " addr_lo"}, addr_lo_q, {a[29:0], 2'b00});
        chk({req, " addr_hi"}, addr_hi_q, {24'd0, a[AW-3:30]});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 log", log_q, 0);
        chk("R1 addr_lo", addr_lo_q, 0);
        chk("R1 addr_hi", addr_hi_q, 0);
        chk("R1 status", {24'd0, int_status}, 0);
        chk("R1 enable", {31'd0, ctl_enable}, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2 disabled: no capture
        drive(1, 0, 8'h5A, 8'h33, 38'h1234, 0, 0, 0);
        chk("R2 status while disabled", {24'd0, int_status}, 0);
        chk("R2 log while disabled", log_q, 0);
        @(negedge clk);
        chk("R2 irq while disabled", {31'd0, irq}, 0);

        drive(0, 0, 0, 0, 0, 1, 1'b0, 1'b1);
        chk("R2 enable set", {31'd0, ctl_enable}, 1);

        for (int i = 0; i < 48; i++) begin
            logic [7:0]    s  = 8'((i * 37 + 5) & 255);
            logic [7:0]    r  = 8'((i * 11 + 3) & 255);
            logic          m  = 1'(i & 1);
            logic [AW-3:0] a  = 38'h12_3456_789A ^ 38'(i * 38'h01_0101_0103);
            logic [7:0]    s2 = ~s;
            logic [7:0]    r2 = r ^ 8'hA5;
            logic [AW-3:0] a2 = ~a;

            // R6 capture visible after the sampling edge
            drive(1, m, s, r, a, 0, 0, 0);
            check_rec("R3 R4 R5 capture", m, s, r, a);
            chk("R6 status set", {24'd0, int_status}, 1);
            chk("R7 irq not yet", {31'd0, irq}, 0);
            @(negedge clk);
            chk("R7 irq raised", {31'd0, irq}, 1);

            // R9 later error dropped
            drive(1, ~m, s2, r2, a2, 0, 0, 0);
            check_rec("R9 held record", m, s, r, a);
            chk("R9 status held", {24'd0, int_status}, 1);

            // R8 writing 0 has no effect
            drive(0, 0, 0, 0, 0, 1, 1'b1, 1'b0);
            check_rec("R8 zero write ignored", m, s, r, a);
            chk("R8 status after zero write", {24'd0, int_status}, 1);

            if (i % 3 == 0) begin
                // R10 clear and new error in the same cycle
                drive(1, ~m, s2, r2, a2, 1, 1'b1, 1'b1);
                check_rec("R10 recapture", ~m, s2, r2, a2);
                chk("R10 status stays", {24'd0, int_status}, 1);
                chk("R10 irq stays", {31'd0, irq}, 1);
            end

            // R8 clear
            drive(0, 0, 0, 0, 0, 1, 1'b1, 1'b1);
            chk("R8 status cleared", {24'd0, int_status}, 0);
            chk("R8 log wiped", log_q, 0);
            chk("R8 addr_lo wiped", addr_lo_q, 0);
            chk("R8 addr_hi wiped", addr_hi_q, 0);
            chk("R7 irq one cycle late", {31'd0, irq}, 1);
            @(negedge clk);
            chk("R7 irq dropped", {31'd0, irq}, 0);
        end

        // R2 disable again
        drive(0, 0, 0, 0, 0, 1, 1'b0, 1'b0);
        chk("R2 enable cleared", {31'd0, ctl_enable}, 0);
        drive(1, 1, 8'hFF, 8'hFF, '1, 0, 0, 0);
        chk("R2 no capture after disable", log_q, 0);
        chk("R2 no status after disable", {24'd0, int_status}, 0);
        @(negedge clk);
        chk("R2 no irq after disable", {31'd0, irq}, 0);

        finish_run();
    end

endmodule